// File: doc/BRIEF.md
# Karatsuba 128-bit carry-less multiplier

This block multiplies two 128-bit polynomials over GF(2) and returns the full 256-bit carry-less product, split into a low half and a high half. Operand bit i is the coefficient of x^i. No modular reduction is applied and the operand bytes are used in the order they arrive.

The 128x128 product is formed from three 64x64 sub-products in Karatsuba form. The three sub-products are low-by-low, high-by-high, and (low xor high) by (low xor high). Each 64x64 sub-product is built from eight-lane 8x8 polynomial byte multiplies. One operand is byte-rotated against the other, each diagonal partial sum is masked and folded, and each fold is rotated into place.

Two configurations are available. The first reuses one 64x64 unit over three cycles. The second instantiates three units and finishes in one cycle. A caller pulses `start_i` with the operands, waits for the one-cycle `done_o` strobe, and reads the result.

Top module: `clmul128_kara`

## Requirements
- R1: While `rst_ni` is low and after its release, `busy_o` and `done_o` are 0, and `res_lo_o` and `res_hi_o` are all zeros until the first product completes.
- R2: A clock edge with `start_i` high and `busy_o` low captures `a_i` and `b_i`, and `busy_o` is 1 after that edge. Later changes of `a_i` and `b_i` do not change the product being computed.
- R3: `start_i` seen while `busy_o` is 1 is ignored. The product that completes is that of the operands captured at acceptance.
- R4: `done_o` is a one-cycle pulse. It rises exactly LAT edges after the accepting edge, with LAT = 3 when `SHARE_UNIT` = 1 and LAT = 1 when `SHARE_UNIT` = 0. `busy_o` falls at the same edge.
- R5: When `done_o` rises, `{res_hi_o, res_lo_o}` equals the carry-less product of the captured operands. Bit k of the 256-bit value is the coefficient of x^k: `res_lo_o` holds x^0..x^127 and `res_hi_o` holds x^128..x^255.
- R6: `res_lo_o` and `res_hi_o` keep their value in every cycle in which `done_o` is 0.
- R7: A zero operand gives an all-zero result. An operand equal to 1 returns the other operand in `res_lo_o`, with `res_hi_o` zero.
- R8: Single-bit operands x^i and x^j give exactly bit i+j set, including positions that cross the 64-bit half and byte-lane boundaries. All-ones operands give the reference product.
- R9: Both configurations return identical results for identical operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a product; accepted only while idle |
| a_i | input | 16*LANES (128) | First operand, bit i = coefficient of x^i |
| b_i | input | 16*LANES (128) | Second operand, bit i = coefficient of x^i |
| busy_o | output | 1 | A product is in progress |
| done_o | output | 1 | One-cycle strobe: result is valid |
| res_lo_o | output | 16*LANES (128) | Product coefficients x^0..x^127 |
| res_hi_o | output | 16*LANES (128) | Product coefficients x^128..x^255 |

## Verification
The assertions assume that reset is asserted from time zero. They also assume that `start_i` is a level sampled on the clock edge, with no further condition on its width. Operands need only be valid at the accepting edge.

The stimulus drives `start_i` and the operands on the falling edge and releases `start_i` after one cycle. The operands are then scrambled on purpose, to show they are not re-read. One scenario raises `start_i` again while both configurations are busy, to show that the extra request is ignored.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

  // 8x8 polynomial byte product
  function automatic logic [15:0] clmul8(input logic [7:0] x, input logic [7:0] y);
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      if (y[i]) r = r ^ ({8'b0, x} << i);
    end
    return r;
  endfunction

endpackage

// File: rtl/clmul_lane_mul.sv
module clmul_lane_mul #(
  parameter int LANES = 8
) (
  input  logic [8*LANES-1:0]  x_i,
  input  logic [8*LANES-1:0]  y_i,
  output logic [16*LANES-1:0] p_o
);
  import clmul_pkg::*;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign p_o[16*i +: 16] = clmul8(x_i[8*i +: 8], y_i[8*i +: 8]);
  end

endmodule

// File: rtl/clmul64_core.sv
module clmul64_core #(
  parameter int LANES = 8
) (
  input  logic [8*LANES-1:0]  a_i,
  input  logic [8*LANES-1:0]  b_i,
  output logic [16*LANES-1:0] p_o
);
  localparam int W    = 8 * LANES;
  localparam int PW   = 2 * W;
  localparam int MAXD = LANES / 2;
  localparam logic [W-1:0] ONE = 1;

  logic [PW-1:0] term [MAXD+1];

  // diagonal 0: lane i holds a_i*b_i, already in place
  clmul_lane_mul #(.LANES(LANES)) u_base (.x_i(a_i), .y_i(b_i), .p_o(term[0]));

  for (genvar d = 1; d <= MAXD; d++) begin : g_off
    localparam int SH   = 8 * d;
    localparam int KEEP = 16 * (MAXD - d);
    localparam logic [W-1:0] KM = (ONE << KEEP) - ONE;

    logic [W-1:0]  rb;
    logic [PW-1:0] s;
    logic [PW-1:0] fold;

    assign rb = (b_i >> SH) | (b_i << (W - SH));

    if (d < MAXD) begin : g_both
      logic [W-1:0]  ra;
      logic [PW-1:0] s_a;
      logic [PW-1:0] s_b;
      assign ra = (a_i >> SH) | (a_i << (W - SH));
      clmul_lane_mul #(.LANES(LANES)) u_a (.x_i(ra),  .y_i(b_i), .p_o(s_a));
      clmul_lane_mul #(.LANES(LANES)) u_b (.x_i(a_i), .y_i(rb),  .p_o(s_b));
      assign s = s_a ^ s_b;
    end else begin : g_single
      // offset MAXD: both directions are the same diagonal set
      clmul_lane_mul #(.LANES(LANES)) u_c (.x_i(a_i), .y_i(rb), .p_o(s));
    end

    // wrapped lanes move down one half so the byte rotation places them right
    assign fold = {s[PW-1:W] & KM, s[W-1:0] ^ (s[PW-1:W] & ~KM)};
    assign term[d] = (fold << SH) | (fold >> (PW - SH));
  end

  always_comb begin
    p_o = '0;
    for (int d = 0; d <= MAXD; d++) p_o = p_o ^ term[d];
  end

endmodule

// File: rtl/clmul_kara_join.sv
module clmul_kara_join #(
  parameter int LANES = 8
) (
  input  logic [16*LANES-1:0] lo_p_i,
  input  logic [16*LANES-1:0] hi_p_i,
  input  logic [16*LANES-1:0] mid_p_i,
  output logic [16*LANES-1:0] res_lo_o,
  output logic [16*LANES-1:0] res_hi_o
);
  localparam int H = 8 * LANES;

  logic [2*H-1:0] mid_t;

  assign mid_t    = mid_p_i ^ lo_p_i ^ hi_p_i;
  assign res_lo_o = lo_p_i ^ {mid_t[H-1:0], {H{1'b0}}};
  assign res_hi_o = hi_p_i ^ {{H{1'b0}}, mid_t[2*H-1:H]};

endmodule

// File: rtl/clmul128_kara.sv
module clmul128_kara #(
  parameter int LANES      = 8,
  parameter bit SHARE_UNIT = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [16*LANES-1:0] a_i,
  input  logic [16*LANES-1:0] b_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [16*LANES-1:0] res_lo_o,
  output logic [16*LANES-1:0] res_hi_o
);
  localparam int H  = 8 * LANES;
  localparam int OW = 2 * H;
  localparam logic [1:0] LAST_PH = SHARE_UNIT ? 2'd2 : 2'd0;

  logic [OW-1:0] a_q, b_q;
  logic [1:0]    phase_q;
  logic          busy_q, done_q;
  logic [OW-1:0] p_lo, p_hi, p_mid;
  logic [OW-1:0] join_lo, join_hi;
  logic [H-1:0]  a_lo, a_hi, b_lo, b_hi;
  logic          accept, last;

  assign a_lo   = a_q[H-1:0];
  assign a_hi   = a_q[OW-1:H];
  assign b_lo   = b_q[H-1:0];
  assign b_hi   = b_q[OW-1:H];
  assign accept = start_i && !busy_q;
  assign last   = busy_q && (phase_q == LAST_PH);

  if (SHARE_UNIT) begin : g_shared
    logic [H-1:0]  op_a, op_b;
    logic [OW-1:0] core_p, lo_q, hi_q;

    always_comb begin
      unique case (phase_q)
        2'd0:    begin op_a = a_lo;        op_b = b_lo;        end
        2'd1:    begin op_a = a_hi;        op_b = b_hi;        end
        default: begin op_a = a_lo ^ a_hi; op_b = b_lo ^ b_hi; end
      endcase
    end

    clmul64_core #(.LANES(LANES)) u_core (.a_i(op_a), .b_i(op_b), .p_o(core_p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (busy_q) begin
        if (phase_q == 2'd0) lo_q <= core_p;
        if (phase_q == 2'd1) hi_q <= core_p;
      end
    end

    assign p_lo  = lo_q;
    assign p_hi  = hi_q;
    assign p_mid = core_p;

    AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> phase_q <= LAST_PH);  // R4
  end else begin : g_parallel
    clmul64_core #(.LANES(LANES)) u_lo  (.a_i(a_lo),        .b_i(b_lo),        .p_o(p_lo));
    clmul64_core #(.LANES(LANES)) u_hi  (.a_i(a_hi),        .b_i(b_hi),        .p_o(p_hi));
    clmul64_core #(.LANES(LANES)) u_mid (.a_i(a_lo ^ a_hi), .b_i(b_lo ^ b_hi), .p_o(p_mid));
  end

  clmul_kara_join #(.LANES(LANES)) u_join (
    .lo_p_i  (p_lo),
    .hi_p_i  (p_hi),
    .mid_p_i (p_mid),
    .res_lo_o(join_lo),
    .res_hi_o(join_hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q      <= '0;
      b_q      <= '0;
      phase_q  <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      res_lo_o <= '0;
      res_hi_o <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        a_q     <= a_i;
        b_q     <= b_i;
        phase_q <= '0;
        busy_q  <= 1'b1;
      end else if (last) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        res_lo_o <= join_lo;
        res_hi_o <= join_hi;
      end else if (busy_q) begin
        phase_q <= phase_q + 2'd1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);  // R2
  AST_OPERANDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(a_q) && $stable(b_q)));  // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R4
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));  // R4
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(res_lo_o) && $stable(res_hi_o)));  // R6

endmodule

// File: tb/test_clmul128_kara.sv
module test_clmul128_kara;
  localparam int  CLK_PERIOD = 10;
  localparam int  OW         = 128;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start = 1'b0;
  logic [OW-1:0] a_in = '0, b_in = '0;
  logic          busy_s, done_s, busy_p, done_p;
  logic [OW-1:0] lo_s, hi_s, lo_p, hi_p;
  int            n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clmul128_kara #(.LANES(8), .SHARE_UNIT(1'b1)) i_clmul128_kara (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .a_i(a_in), .b_i(b_in),
    .busy_o(busy_s), .done_o(done_s), .res_lo_o(lo_s), .res_hi_o(hi_s));

  clmul128_kara #(.LANES(8), .SHARE_UNIT(1'b0)) i_clmul128_kara_par (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .a_i(a_in), .b_i(b_in),
    .busy_o(busy_p), .done_o(done_p), .res_lo_o(lo_p), .res_hi_o(hi_p));

  function automatic logic [255:0] ref_mul(input logic [OW-1:0] a, input logic [OW-1:0] b);
    logic [255:0] r;
    r = '0;
    for (int i = 0; i < OW; i++) if (b[i]) r = r ^ ({128'b0, a} << i);
    return r;
  endfunction

  function automatic logic [OW-1:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one product on both configurations; checks R2 R4 R5 R6 R9
  task automatic run_pair(input logic [OW-1:0] a, input logic [OW-1:0] b,
                          input string req, input bit poke_busy);
    logic [255:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk);
    a_in = a; b_in = b; start = 1'b1;
    @(negedge clk);  // after accepting edge
    start = poke_busy;  // R3: second request while busy
    a_in = ~a ^ b; b_in = a ^ {b[63:0], b[127:64]};
    chk(busy_s && busy_p && !done_s && !done_p, "R2 busy after accept",
        {252'b0, busy_s, busy_p, done_s, done_p}, {252'b0, 4'b1100});
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk);
      start = 1'b0;
      chk(done_s == (k == 4) && done_p == (k == 2), "R4 done timing",
          {254'b0, done_s, done_p}, {254'b0, k == 4, k == 2});
      chk(busy_s == (k < 4) && !busy_p, "R4 busy release",
          {254'b0, busy_s, busy_p}, {254'b0, k < 4, 1'b0});
      if (k == 2) chk({hi_p, lo_p} == exp, {req, " parallel"}, {hi_p, lo_p}, exp);
      if (k == 4) begin
        chk({hi_s, lo_s} == exp, {req, " shared"}, {hi_s, lo_s}, exp);
        chk({hi_s, lo_s} == {hi_p, lo_p}, "R9 configs agree", {hi_s, lo_s}, {hi_p, lo_p});
      end
    end
    @(negedge clk);
    chk(!done_s && !done_p && {hi_s, lo_s} == exp && {hi_p, lo_p} == exp,
        "R6 result held", {hi_s, lo_s}, exp);
  endtask

  task automatic test_reset();
    chk(!busy_s && !done_s && !busy_p && !done_p, "R1 flags in reset",
        {252'b0, busy_s, done_s, busy_p, done_p}, '0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk({hi_s, lo_s} == '0 && {hi_p, lo_p} == '0 && !busy_s && !busy_p,
        "R1 state after reset", {hi_s, lo_s}, '0);
  endtask

  task automatic test_zero_one();
    logic [OW-1:0] x;
    x = rnd128();
    run_pair('0, x, "R7 zero times x", 1'b0);
    run_pair(x, '0, "R7 x times zero", 1'b0);
    run_pair(128'd1, x, "R7 one times x", 1'b0);
    chk(hi_s == '0 && lo_s == x, "R7 identity halves", {hi_s, lo_s}, {128'b0, x});
    run_pair(x, 128'd1, "R7 x times one", 1'b0);
  endtask

  task automatic test_all_ones();
    run_pair('1, '1, "R8 all ones", 1'b0);
    run_pair('1, 128'd1 << 127, "R8 ones times top bit", 1'b0);
  endtask

  task automatic test_single_bits();
    int pos [8] = '{0, 7, 8, 63, 64, 71, 120, 127};
    foreach (pos[i]) begin
      logic [255:0] e;
      int j;
      j = pos[7 - i];
      e = 256'd1 << (pos[i] + j);
      run_pair(128'd1 << pos[i], 128'd1 << j, "R8 single bits", 1'b0);
      chk({hi_s, lo_s} == e, "R8 single bit position", {hi_s, lo_s}, e);
    end
  endtask

  task automatic test_random();
    for (int n = 0; n < 24; n++) run_pair(rnd128(), rnd128(), "R5 random product", 1'b0);
    run_pair({64'hffff_0000_ffff_0000, 64'h0123_4567_89ab_cdef},
             {64'h8000_0000_0000_0001, 64'hfedc_ba98_7654_3210}, "R5 patterned", 1'b0);
  endtask

  task automatic test_start_busy();
    run_pair(rnd128(), rnd128(), "R3 start while busy ignored", 1'b1);
    run_pair(rnd128(), rnd128(), "R3 next product after ignore", 1'b0);
  endtask

  initial begin
    test_reset();
    test_zero_one();
    test_all_ones();
    test_single_bits();
    test_random();
    test_start_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule